// File: doc/BRIEF.md
# Vector Block Shuffle Unit

This unit rearranges a vector of up to eight 32-bit blocks (256 bits in total). It moves whole blocks across the vector: it rotates the vector by a number of blocks, pushes a 32-bit scalar in at the bottom, or pops the bottom block out as a scalar. It also rotates the bits inside each block, either by a fixed amount from 0 to 3 or by a separate amount for each block, packed one byte per block into a 64-bit control operand.

Each operation works on the active vector width of 64, 128 or 256 bits. Blocks above that width stay as they are and take no part in the operation. A start strobe loads the operands. The result vector and the popped scalar are registered and appear one cycle later together with a valid pulse. They then hold until the next strobe.

Top module: `vbs_top`

## Requirements
- R1: While rst is high and after it falls, vec_out and scalar_out read zero and valid is low until the first start.
- R2: A start in one cycle gives valid high in the next cycle only. vec_out and scalar_out change only in the cycle after a start and hold their value otherwise.
- R3: op 0 rotates the active blocks toward higher significance by amt blocks, so active block i takes block (i-amt) modulo the active block count. op 1 rotates them toward lower significance, so block i takes block (i+amt) modulo the count.
- R4: wsel 0 selects 2 active blocks (64 bits) and wsel 1 selects 4 (128 bits). wsel 2 and 3 select 8 (256 bits). For every op, blocks at or above the active count come out equal to their input.
- R5: op 2 (push) moves each active block up one position, drops the top active block and puts scalar_in in block 0. scalar_out is zero.
- R6: op 3 (pop) returns block 0 on scalar_out, moves the other active blocks down one position and zeroes the top active block. Every op other than pop returns zero on scalar_out.
- R7: op 4 rotates the bits of each active block left (toward the MSB) by amt[1:0]. op 5 rotates them right by the same amount. An amount of 0 leaves the block unchanged.
- R8: op 6 rotates each active block i left by the low 5 bits of byte i of {ctrl_hi, ctrl_lo}, with byte 0 in ctrl_lo[7:0] controlling block 0. op 7 does the same rotation to the right. The upper 3 bits of each byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads operands; result follows next cycle |
| op | input | 3 | Operation code (see R3 to R8) |
| wsel | input | 2 | Active width select (see R4) |
| amt | input | 3 | Block count or fixed bit amount |
| vec_in | input | 256 | Source vector, block 0 in bits 31:0 |
| scalar_in | input | 32 | Scalar for push |
| ctrl_lo | input | 32 | Per-block amounts for blocks 0 to 3 |
| ctrl_hi | input | 32 | Per-block amounts for blocks 4 to 7 |
| vec_out | output | 256 | Registered result vector |
| scalar_out | output | 32 | Registered popped scalar |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench aims at wrap-around of the rotation amount at each width: amt 7 on a 64-bit vector must act as a rotation by one block. A design that used a fixed modulus of eight would move data into the frozen upper blocks or lose it. Push and pop at narrow widths check that the dropped or zeroed block is the top active block and not block 7. A fixed amount of 0 and per-block amounts with the ignored upper bits set check that a design does not rotate by 32 or read three extra bits. Per-block amounts that are all different catch byte order swapped between ctrl_lo and ctrl_hi. The bench also changes vec_in between start strobes to show that a result latching without a strobe would break the hold rule.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [2:0] {
    OP_BLK_ROL  = 3'd0,
    OP_BLK_ROR  = 3'd1,
    OP_PUSH     = 3'd2,
    OP_POP      = 3'd3,
    OP_BIT_ROL  = 3'd4,
    OP_BIT_ROR  = 3'd5,
    OP_VAR_ROL  = 3'd6,
    OP_VAR_ROR  = 3'd7
  } vbs_op_e;
endpackage

// File: rtl/vbs_lane_rot.sv
module vbs_lane_rot #(
  parameter int BLK_W = 32,
  localparam int SH_W = $clog2(BLK_W)
) (
  input  logic [BLK_W-1:0] din,
  input  logic [SH_W-1:0]  sh,
  input  logic             dir_right,
  output logic [BLK_W-1:0] dout
);
  logic [2*BLK_W-1:0] dbl_l, dbl_r;

  always_comb begin
    dbl_l = {din, din} << sh;
    dbl_r = {din, din} >> sh;
    dout  = dir_right ? dbl_r[BLK_W-1:0] : dbl_l[2*BLK_W-1:BLK_W];
  end
endmodule

// File: rtl/vbs_xblock.sv
module vbs_xblock
  import vbs_pkg::*;
#(
  parameter int BLK_W = 32,
  parameter int NBLK  = 8,
  localparam int VEC_W = BLK_W * NBLK,
  localparam int AMT_W = $clog2(NBLK),
  localparam int LG_W  = $clog2(AMT_W + 1)
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [BLK_W-1:0] scalar,
  input  vbs_op_e          op,
  input  logic [LG_W-1:0]  act_lg,
  input  logic [AMT_W-1:0] amt,
  output logic [VEC_W-1:0] vec_res,
  output logic [BLK_W-1:0] pop_val
);
  always_comb begin
    int nact;
    int k;
    int src;
    vec_res = vec;
    pop_val = '0;
    nact = 1 << int'(act_lg);
    k    = int'(amt) % nact;
    for (int i = 0; i < NBLK; i++) begin
      src = i;
      if (i < nact) begin
        unique case (op)
          OP_BLK_ROL: begin
            src = (i - k + nact) % nact;
            vec_res[i*BLK_W +: BLK_W] = vec[src*BLK_W +: BLK_W];
          end
          OP_BLK_ROR: begin
            src = (i + k) % nact;
            vec_res[i*BLK_W +: BLK_W] = vec[src*BLK_W +: BLK_W];
          end
          OP_PUSH: begin
            if (i == 0) vec_res[BLK_W-1:0] = scalar;
            else begin
              src = i - 1;
              vec_res[i*BLK_W +: BLK_W] = vec[src*BLK_W +: BLK_W];
            end
          end
          OP_POP: begin
            if (i == nact - 1) vec_res[i*BLK_W +: BLK_W] = '0;
            else begin
              src = i + 1;
              vec_res[i*BLK_W +: BLK_W] = vec[src*BLK_W +: BLK_W];
            end
          end
          default: ;
        endcase
      end
    end
    if (op == OP_POP) pop_val = vec[BLK_W-1:0];
  end
endmodule

// File: rtl/vbs_top.sv
module vbs_top
  import vbs_pkg::*;
#(
  parameter int BLK_W = 32,
  parameter int NBLK  = 8,
  localparam int VEC_W  = BLK_W * NBLK,
  localparam int CTRL_W = 8 * NBLK,
  localparam int AMT_W  = $clog2(NBLK),
  localparam int SH_W   = $clog2(BLK_W),
  localparam int LG_W   = $clog2(AMT_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [1:0]          wsel,
  input  logic [AMT_W-1:0]    amt,
  input  logic [VEC_W-1:0]    vec_in,
  input  logic [BLK_W-1:0]    scalar_in,
  input  logic [CTRL_W/2-1:0] ctrl_lo,
  input  logic [CTRL_W/2-1:0] ctrl_hi,
  output logic [VEC_W-1:0]    vec_out,
  output logic [BLK_W-1:0]    scalar_out,
  output logic                valid
);
  vbs_op_e          op_e;
  logic [LG_W-1:0]  act_lg;
  logic [CTRL_W-1:0] ctrl;
  logic [VEC_W-1:0] xres, bres, res_next;
  logic [BLK_W-1:0] pop_next;
  logic             is_bitop, is_var, go_right;

  always_comb begin
    op_e     = vbs_op_e'(op);
    ctrl     = {ctrl_hi, ctrl_lo};
    is_bitop = op[2];
    is_var   = op[2] & op[1];
    go_right = op[0];
    unique case (wsel)
      2'd0:    act_lg = LG_W'(1);
      2'd1:    act_lg = LG_W'(2);
      default: act_lg = LG_W'(AMT_W);
    endcase
  end

  vbs_xblock #(.BLK_W(BLK_W), .NBLK(NBLK)) xblk_i (
    .vec     (vec_in),
    .scalar  (scalar_in),
    .op      (op_e),
    .act_lg  (act_lg),
    .amt     (amt),
    .vec_res (xres),
    .pop_val (pop_next)
  );

  for (genvar g = 0; g < NBLK; g++) begin : g_lane
    logic [SH_W-1:0]  sh;
    logic [BLK_W-1:0] rot;
    logic             lane_act;
    assign sh       = is_var ? ctrl[g*8 +: SH_W] : SH_W'(amt[1:0]);
    assign lane_act = (g < (1 << int'(act_lg)));
    vbs_lane_rot #(.BLK_W(BLK_W)) rot_i (
      .din       (vec_in[g*BLK_W +: BLK_W]),
      .sh        (sh),
      .dir_right (go_right),
      .dout      (rot)
    );
    assign bres[g*BLK_W +: BLK_W] = lane_act ? rot : vec_in[g*BLK_W +: BLK_W];
  end

  assign res_next = is_bitop ? bres : xres;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out    <= '0;
      scalar_out <= '0;
      valid      <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        vec_out    <= res_next;
        scalar_out <= pop_next;
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> valid); // R2
  AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(vec_out) && $stable(scalar_out)); // R2
  AST_NARROW_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    start && wsel == 2'd0 |=> vec_out[VEC_W-1:2*BLK_W] == $past(vec_in[VEC_W-1:2*BLK_W])); // R4
  AST_PUSH_LOWEST: assert property (@(posedge clk) disable iff (rst)
    start && op == 3'd2 |=> vec_out[BLK_W-1:0] == $past(scalar_in)); // R5
  AST_POP_VALUE: assert property (@(posedge clk) disable iff (rst)
    start && op == 3'd3 |=> scalar_out == $past(vec_in[BLK_W-1:0])); // R6
  AST_SCALAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    start && op != 3'd3 |=> scalar_out == '0); // R6
endmodule

// File: tb/vbs_top_tb_top.sv
module vbs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [2:0]   op;
  logic [1:0]   wsel;
  logic [2:0]   amt;
  logic [255:0] vec_in;
  logic [31:0]  scalar_in, ctrl_lo, ctrl_hi;
  logic [255:0] vec_out;
  logic [31:0]  scalar_out;
  logic         valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbs_top dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .wsel(wsel), .amt(amt),
    .vec_in(vec_in), .scalar_in(scalar_in), .ctrl_lo(ctrl_lo), .ctrl_hi(ctrl_hi),
    .vec_out(vec_out), .scalar_out(scalar_out), .valid(valid)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bitrot(input logic [31:0] x, input int a, input bit right);
    logic [31:0] y = x;
    for (int s = 0; s < a; s++)
      y = right ? {y[0], y[31:1]} : {y[30:0], y[31]};
    return y;
  endfunction

  function automatic void model(input logic [2:0] o, input logic [1:0] w, input logic [2:0] a,
                                input logic [255:0] v, input logic [31:0] s,
                                input logic [63:0] c,
                                output logic [255:0] ev, output logic [31:0] es);
    logic [31:0] b[8];
    logic [31:0] t;
    int n;
    for (int j = 0; j < 8; j++) b[j] = v[j*32 +: 32];
    n = (w == 2'd0) ? 2 : (w == 2'd1) ? 4 : 8;
    es = '0;
    case (o)
      3'd0: for (int r = 0; r < int'(a); r++) begin
              t = b[n-1];
              for (int j = n-1; j > 0; j--) b[j] = b[j-1];
              b[0] = t;
            end
      3'd1: for (int r = 0; r < int'(a); r++) begin
              t = b[0];
              for (int j = 0; j < n-1; j++) b[j] = b[j+1];
              b[n-1] = t;
            end
      3'd2: begin
              for (int j = n-1; j > 0; j--) b[j] = b[j-1];
              b[0] = s;
            end
      3'd3: begin
              es = b[0];
              for (int j = 0; j < n-1; j++) b[j] = b[j+1];
              b[n-1] = '0;
            end
      3'd4, 3'd5: for (int j = 0; j < n; j++) b[j] = bitrot(b[j], int'(a[1:0]), o[0]);
      default: for (int j = 0; j < n; j++) b[j] = bitrot(b[j], int'(c[j*8 +: 5]), o[0]);
    endcase
    for (int j = 0; j < 8; j++) ev[j*32 +: 32] = b[j];
  endfunction

  task automatic run_op(input string req, input logic [2:0] o, input logic [1:0] w,
                        input logic [2:0] a, input logic [255:0] v, input logic [31:0] s,
                        input logic [63:0] c);
    logic [255:0] ev;
    logic [31:0]  es;
    model(o, w, a, v, s, c, ev, es);
    @(negedge clk);
    op = o; wsel = w; amt = a; vec_in = v; scalar_in = s;
    ctrl_lo = c[31:0]; ctrl_hi = c[63:32]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R2 valid ", req}, {255'd0, valid}, 256'd1);
    check({req, " vec"}, vec_out, ev);
    check({"R6 scalar ", req}, {224'd0, scalar_out}, {224'd0, es});
    vec_in = ~v; scalar_in = ~s;
    @(negedge clk);
    check({"R2 hold valid ", req}, {255'd0, valid}, 256'd0);
    check({"R2 hold vec ", req}, vec_out, ev);
  endtask

  function automatic logic [255:0] rvec();
    logic [255:0] r;
    for (int j = 0; j < 8; j++) r[j*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    logic [255:0] pat;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst = 1'b1; start = 1'b0; op = '0; wsel = '0; amt = '0;
    vec_in = '1; scalar_in = '1; ctrl_lo = '0; ctrl_hi = '0;
    repeat (3) @(negedge clk);
    check("R1 reset vec", vec_out, '0);
    check("R1 reset scalar", {224'd0, scalar_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid", {255'd0, valid}, '0);
    check("R1 idle vec", vec_out, '0);

    for (int j = 0; j < 8; j++) pat[j*32 +: 32] = 32'h1000_0000 * (j + 1) + 32'(j);
    run_op("R3 rol 256 by 3", 3'd0, 2'd2, 3'd3, pat, 32'h0, 64'h0);
    run_op("R3 ror 128 by 1", 3'd1, 2'd1, 3'd1, pat, 32'h0, 64'h0);
    run_op("R4 rol 64 amt 7 wraps", 3'd0, 2'd0, 3'd7, pat, 32'h0, 64'h0);
    run_op("R4 ror 64 amt 6", 3'd1, 2'd0, 3'd6, pat, 32'h0, 64'h0);
    run_op("R4 wsel 3 acts as 256", 3'd0, 2'd3, 3'd5, pat, 32'h0, 64'h0);
    run_op("R5 push 128", 3'd2, 2'd1, 3'd0, pat, 32'hCAFE_F00D, 64'h0);
    run_op("R5 push 64", 3'd2, 2'd0, 3'd0, pat, 32'hDEAD_BEEF, 64'h0);
    run_op("R6 pop 256", 3'd3, 2'd2, 3'd0, pat, 32'h0, 64'h0);
    run_op("R6 pop 64", 3'd3, 2'd0, 3'd0, pat, 32'h0, 64'h0);
    run_op("R7 bit rol amt 0", 3'd4, 2'd2, 3'd4, pat, 32'h0, 64'h0);
    run_op("R7 bit ror 3 at 128", 3'd5, 2'd1, 3'd3, pat, 32'h0, 64'h0);
    run_op("R8 var rol high bits ignored", 3'd6, 2'd2, 3'd0, pat, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R8 var ror distinct", 3'd7, 2'd2, 3'd0, pat, 32'h0, 64'h1F10_0803_0201_0004);
    run_op("R8 var rol 64", 3'd6, 2'd0, 3'd0, pat, 32'h0, 64'h0505_0505_0901_E702);

    for (int r = 0; r < 400; r++) begin
      logic [2:0] ro;
      ro = 3'($urandom);
      run_op(ro < 2 ? "R3 random" : ro < 4 ? "R5/R6 random" : ro < 6 ? "R7 random" : "R8 random",
             ro, 2'($urandom), 3'($urandom), rvec(), $urandom, {$urandom, $urandom});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule